// File: doc/BRIEF.md
# Flash Command Mailbox Engine

This block is the device side of a command mailbox that lets a host manage a small on-chip flash array through a plain register port. The port has an address, a write enable, write data and read data. Three things sit behind it. Register indices 0 to 15 are a sixteen-dword data buffer. Index 16 is the command register and index 17 is the status register. The host first places data in the buffer. It then writes a command word with bit 0 set. Bit 0 reads back as 1 while the engine works and drops to 0 once the job is finished.

The engine decodes the opcode, the dword count, the dword address and the header-select bit. It then copies dwords between the buffer and the flash, or checks a signature held in the header area of the flash, or pulses a reset request. Every command ends with a status word. That word returns the opcode of the command and its result code.

Reads return data one cycle after the address is presented. A fixed extra busy latency is added before each command completes, so host polling can be exercised.

Top module: `fmbx_engine`

## Requirements
- R1: A write command has opcode 4'h0 in bits 31:28 of the command word. It copies buffer dwords 0..N-1 into flash dwords A..A+N-1, where A is bits 23:2 and N is bits 27:24 plus one.
- R2: A read command has opcode 4'h2. It copies flash dwords A..A+N-1 into buffer dwords 0..N-1, with N equal to bits 27:24 and a field value of 0 meaning 16. Buffer dwords N..15 are left unchanged.
- R3: A write with header select (bit 1) set stores its dwords starting at flash dword HDR_ADDR, whatever the address field holds. The flash at the address given in the field is left unchanged.
- R4: From the cycle a command is accepted until it completes, bit 0 of the command register reads 1. After completion the command register reads back the accepted word with bit 0 cleared.
- R5: Status register bits 3:0 hold the result (0 completed, 1 authentication error, 2 access error). Bits 7:4 hold the opcode of the finished command, bit 29 is 1 and every other bit is 0.
- R6: A read or write whose range A+N goes past FLASH_DEPTH completes with result 2 and changes neither the flash nor the buffer. Any opcode other than 0, 1, 2 and 4 also completes with result 2.
- R7: A write to the command register is ignored while a command runs, and so is a write with bit 0 clear. Buffer writes from the host are also ignored while a command runs.
- R8: Update-authenticate (opcode 4'h1) reports result 0 when flash dword HDR_ADDR equals SIGNATURE and result 1 otherwise.
- R9: Power cycle (opcode 4'h4) raises rst_req for exactly one cycle and then completes with result 0.
- R10: Bit 0 of the command register stays set for at least BUSY_LAT cycles after any command is accepted.
- R11: After reset the command register, the status register, reg_rdata and rst_req are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register index: 0-15 buffer, 16 command, 17 status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the address presented one cycle earlier |
| rst_req | output | 1 | One-cycle reset request raised by power cycle |

## Verification
The flash is first filled completely through write commands, so every later read has a known value to compare against. Directed cases follow. A zero count on a read tells the full sixteen-dword transfer apart from a one-dword transfer. Ranges that end exactly at the last dword of the flash are run next to ranges one dword past it, which shows where the access check sits. Header writes use a nonzero address field, which shows that the address is overridden. Authentication runs with a bad signature and then a good one, and host writes are placed inside busy windows. After that, random opcodes, addresses, counts and header bits are checked against a bench model of flash and buffer. The bench reads back all sixteen buffer dwords after every command, so a stray buffer write shows up.

// File: rtl/fmbx_pkg.sv
package fmbx_pkg;

  localparam logic [3:0] OP_WRITE = 4'h0;
  localparam logic [3:0] OP_AUTH  = 4'h1;
  localparam logic [3:0] OP_READ  = 4'h2;
  localparam logic [3:0] OP_PCYC  = 4'h4;

  localparam logic [3:0] RES_OK     = 4'h0;
  localparam logic [3:0] RES_AUTH   = 4'h1;
  localparam logic [3:0] RES_ACCESS = 4'h2;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  cnt;
    logic [21:0] addr;
    logic        hdr;
    logic        req;
  } cmd_t;

  function automatic logic [31:0] mk_status(logic [3:0] op, logic [3:0] res);
    return {2'b00, 1'b1, 21'd0, op, res};
  endfunction

endpackage

// File: rtl/fmbx_sp_ram.sv
module fmbx_sp_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/fmbx_dp_ram.sv
module fmbx_dp_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_q,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wdata,
  output logic [W-1:0]  b_q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/fmbx_seq.sv
module fmbx_seq
  import fmbx_pkg::*;
#(
  parameter int          BUF_DW      = 16,
  parameter int          FLASH_DEPTH = 256,
  parameter int          HDR_ADDR    = 240,
  parameter logic [31:0] SIGNATURE   = 32'h5A17_C0DE,
  parameter int          BUSY_LAT    = 8,
  localparam int BUF_AW = $clog2(BUF_DW),
  localparam int FL_AW  = $clog2(FLASH_DEPTH),
  localparam int CNT_W  = BUF_AW + 1,
  localparam int LAT_W  = $clog2(BUSY_LAT + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       status_o,
  output logic              fl_we_o,
  output logic [FL_AW-1:0]  fl_addr_o,
  output logic [31:0]       fl_wdata_o,
  input  logic [31:0]       fl_q_i,
  output logic              bf_we_o,
  output logic [BUF_AW-1:0] bf_addr_o,
  output logic [31:0]       bf_wdata_o,
  input  logic [31:0]       bf_q_i,
  output logic              rst_req_o
);

  typedef enum logic [3:0] {
    S_IDLE, S_DECODE, S_XRD, S_XWR, S_AUTH_RD, S_AUTH_CMP, S_PCYC, S_WAIT, S_DONE
  } st_e;

  st_e               state;
  logic [3:0]        op_r, cnt_r, res_r;
  logic [21:0]       addr_r;
  logic              hdr_r;
  logic [FL_AW-1:0]  base_r;
  logic [CNT_W-1:0]  n_r, idx_r;
  logic [LAT_W-1:0]  lat_r;
  logic              rst_req_q;

  // decode of the latched command word
  logic [CNT_W-1:0]  n_wr, n_rd, n_sel;
  logic [21:0]       start_sel;
  logic              is_wr, in_range;

  always_comb begin
    is_wr     = (op_r == OP_WRITE);
    n_wr      = CNT_W'(cnt_r) + CNT_W'(1);
    n_rd      = (cnt_r == 4'd0) ? CNT_W'(BUF_DW) : CNT_W'(cnt_r);
    n_sel     = is_wr ? n_wr : n_rd;
    start_sel = (is_wr && hdr_r) ? 22'(HDR_ADDR) : addr_r;
    in_range  = ({1'b0, start_sel} + 23'(n_sel)) <= 23'(FLASH_DEPTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_r      <= '0;
      cnt_r     <= '0;
      addr_r    <= '0;
      hdr_r     <= 1'b0;
      res_r     <= RES_OK;
      base_r    <= '0;
      n_r       <= '0;
      idx_r     <= '0;
      lat_r     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            op_r   <= cmd_i.op;
            cnt_r  <= cmd_i.cnt;
            addr_r <= cmd_i.addr;
            hdr_r  <= cmd_i.hdr;
            lat_r  <= '0;
            state  <= S_DECODE;
          end
        end
        S_DECODE: begin
          case (op_r)
            OP_WRITE, OP_READ: begin
              if (in_range) begin
                base_r <= start_sel[FL_AW-1:0];
                n_r    <= n_sel;
                idx_r  <= '0;
                state  <= S_XRD;
              end else begin
                res_r <= RES_ACCESS;
                state <= S_WAIT;
              end
            end
            OP_AUTH: state <= S_AUTH_RD;
            OP_PCYC: state <= S_PCYC;
            default: begin
              res_r <= RES_ACCESS;
              state <= S_WAIT;
            end
          endcase
        end
        S_XRD: state <= S_XWR;
        S_XWR: begin
          if (idx_r + CNT_W'(1) == n_r) begin
            res_r <= RES_OK;
            state <= S_WAIT;
          end else begin
            idx_r <= idx_r + CNT_W'(1);
            state <= S_XRD;
          end
        end
        S_AUTH_RD:  state <= S_AUTH_CMP;
        S_AUTH_CMP: begin
          res_r <= (fl_q_i == SIGNATURE) ? RES_OK : RES_AUTH;
          state <= S_WAIT;
        end
        S_PCYC: begin
          rst_req_q <= 1'b1;
          res_r     <= RES_OK;
          state     <= S_WAIT;
        end
        S_WAIT: begin
          if (lat_r == LAT_W'(BUSY_LAT)) state <= S_DONE;
          else lat_r <= lat_r + LAT_W'(1);
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o     = (state != S_IDLE);
    done_o     = (state == S_DONE);
    status_o   = mk_status(op_r, res_r);
    fl_addr_o  = (state == S_AUTH_RD) ? FL_AW'(HDR_ADDR) : base_r + FL_AW'(idx_r);
    fl_we_o    = (state == S_XWR) && (op_r == OP_WRITE);
    fl_wdata_o = bf_q_i;
    bf_addr_o  = idx_r[BUF_AW-1:0];
    bf_we_o    = (state == S_XWR) && (op_r == OP_READ);
    bf_wdata_o = fl_q_i;
    rst_req_o  = rst_req_q;
  end

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |=> !rst_req_q) else $error("reset request longer than one cycle"); // R9
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == S_XWR) |-> (idx_r < n_r)) else $error("transfer index past count"); // R2
  AST_PULSE_FROM_PCYC: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |-> (op_r == OP_PCYC)) else $error("reset request from wrong opcode"); // R9

endmodule

// File: rtl/fmbx_engine.sv
module fmbx_engine
  import fmbx_pkg::*;
#(
  parameter int          BUF_DW      = 16,
  parameter int          FLASH_DEPTH = 256,
  parameter int          HDR_ADDR    = 240,
  parameter logic [31:0] SIGNATURE   = 32'h5A17_C0DE,
  parameter int          BUSY_LAT    = 8,
  localparam int BUF_AW = $clog2(BUF_DW),
  localparam int FL_AW  = $clog2(FLASH_DEPTH),
  localparam int REG_AW = BUF_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              rst_req
);

  localparam logic [REG_AW-1:0] A_CMD  = REG_AW'(BUF_DW);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(BUF_DW + 1);

  logic [31:0]       cmd_q, stat_q, ctl_q;
  logic [REG_AW-1:0] rd_sel_q;
  logic              busy, done, start;
  logic [31:0]       done_status;

  logic              fl_we;
  logic [FL_AW-1:0]  fl_addr;
  logic [31:0]       fl_wdata, fl_q;
  logic              bf_b_we, bf_a_we;
  logic [BUF_AW-1:0] bf_b_addr;
  logic [31:0]       bf_b_wdata, bf_b_q, bf_a_q;

  assign start   = reg_we && (reg_addr == A_CMD) && reg_wdata[0] && !busy;
  assign bf_a_we = reg_we && (reg_addr < REG_AW'(BUF_DW)) && !busy;

  fmbx_dp_ram #(.W(32), .DEPTH(BUF_DW)) u_buf (
    .clk     (clk),
    .a_we    (bf_a_we),
    .a_addr  (reg_addr[BUF_AW-1:0]),
    .a_wdata (reg_wdata),
    .a_q     (bf_a_q),
    .b_we    (bf_b_we),
    .b_addr  (bf_b_addr),
    .b_wdata (bf_b_wdata),
    .b_q     (bf_b_q)
  );

  fmbx_sp_ram #(.W(32), .DEPTH(FLASH_DEPTH)) u_flash (
    .clk   (clk),
    .we    (fl_we),
    .addr  (fl_addr),
    .wdata (fl_wdata),
    .q     (fl_q)
  );

  fmbx_seq #(
    .BUF_DW      (BUF_DW),
    .FLASH_DEPTH (FLASH_DEPTH),
    .HDR_ADDR    (HDR_ADDR),
    .SIGNATURE   (SIGNATURE),
    .BUSY_LAT    (BUSY_LAT)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .cmd_i      (cmd_t'(reg_wdata)),
    .busy_o     (busy),
    .done_o     (done),
    .status_o   (done_status),
    .fl_we_o    (fl_we),
    .fl_addr_o  (fl_addr),
    .fl_wdata_o (fl_wdata),
    .fl_q_i     (fl_q),
    .bf_we_o    (bf_b_we),
    .bf_addr_o  (bf_b_addr),
    .bf_wdata_o (bf_b_wdata),
    .bf_q_i     (bf_b_q),
    .rst_req_o  (rst_req)
  );

  // command and status registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      stat_q <= '0;
    end else begin
      if (start) cmd_q <= reg_wdata;
      else if (done) cmd_q[0] <= 1'b0;
      if (done) stat_q <= done_status;
    end
  end

  // read path: one cycle from address to data
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q <= A_CMD;
      ctl_q    <= '0;
    end else begin
      rd_sel_q <= reg_addr;
      ctl_q    <= (reg_addr == A_CMD)  ? cmd_q :
                  (reg_addr == A_STAT) ? stat_q : 32'd0;
    end
  end

  assign reg_rdata = (rd_sel_q < REG_AW'(BUF_DW)) ? bf_a_q : ctl_q;

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> cmd_q[0]) else $error("request bit clear while busy"); // R4
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_q)) else $error("command changed while busy"); // R7
  AST_STAT_ECHO: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (stat_q[29] && stat_q[7:4] == cmd_q[31:28] && !cmd_q[0]))
    else $error("status does not echo opcode"); // R5
  AST_NO_FLASH_WE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fl_we) else $error("flash written while idle"); // R6

endmodule

// File: tb/fmbx_engine_tb.sv
module fmbx_engine_tb;
  localparam int          BUF_DW      = 16;
  localparam int          FLASH_DEPTH = 256;
  localparam int          HDR_ADDR    = 240;
  localparam logic [31:0] SIG         = 32'h5A17_C0DE;
  localparam int          BUSY_LAT    = 8;
  localparam logic [4:0]  CMD_A       = 5'd16;
  localparam logic [4:0]  STAT_A      = 5'd17;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rst_req;

  int nvec = 0, nfail = 0, pulses = 0;
  bit fin = 0;
  logic [31:0] fm [FLASH_DEPTH];
  logic [31:0] bm [BUF_DW];
  logic [31:0] last_stat;

  always #4 clk = ~clk;

  fmbx_engine #(.BUF_DW(BUF_DW), .FLASH_DEPTH(FLASH_DEPTH), .HDR_ADDR(HDR_ADDR),
                .SIGNATURE(SIG), .BUSY_LAT(BUSY_LAT)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req));

  always @(negedge clk) if (!rst && rst_req) pulses++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [4:0] a, logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mkw(logic [3:0] op, logic [3:0] cnt, int unsigned a, bit hdr);
    return {op, cnt, a[21:0], hdr, 1'b1};
  endfunction

  // bench model of one command: updates fm/bm, returns expected status
  function automatic logic [31:0] model(logic [31:0] w);
    logic [3:0] op = w[31:28], cnt = w[27:24], res;
    int base = int'(w[23:2]);
    int n;
    res = 4'h2;
    case (op)
      4'h0: begin
        n = int'(cnt) + 1;
        if (w[1]) base = HDR_ADDR;
        if (base + n <= FLASH_DEPTH) begin
          for (int i = 0; i < n; i++) fm[base + i] = bm[i];
          res = 4'h0;
        end
      end
      4'h2: begin
        n = (cnt == 0) ? BUF_DW : int'(cnt);
        if (base + n <= FLASH_DEPTH) begin
          for (int i = 0; i < n; i++) bm[i] = fm[base + i];
          res = 4'h0;
        end
      end
      4'h1: res = (fm[HDR_ADDR] == SIG) ? 4'h0 : 4'h1;
      4'h4: res = 4'h0;
      default: res = 4'h2;
    endcase
    return 32'h2000_0000 | {24'd0, op, res};
  endfunction

  task automatic load_buf();
    for (int i = 0; i < BUF_DW; i++) begin
      bm[i] = $urandom;
      reg_wr(5'(i), bm[i]);
    end
  endtask

  task automatic wait_done(output int lat);
    logic [31:0] v;
    lat = 0;
    do begin
      reg_rd(CMD_A, v);
      lat++;
    end while (v[0] && lat < 2000);
  endtask

  task automatic check_buf(string tag);
    logic [31:0] v;
    for (int i = 0; i < BUF_DW; i++) begin
      reg_rd(5'(i), v);
      chk(tag, v, bm[i]);
    end
  endtask

  task automatic do_cmd(string tag, logic [31:0] w);
    logic [31:0] exp, st;
    int lat;
    exp = model(w);
    reg_wr(CMD_A, w);
    wait_done(lat);
    reg_rd(STAT_A, st);
    chk({tag, " R5 status"}, st, exp);
    chk("R10 busy latency", 32'(lat >= BUSY_LAT), 32'd1);
    last_stat = exp;
    check_buf({tag, " buffer"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w1;
    int lat;
    void'($urandom(32'd4242));
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R11 rdata after reset", reg_rdata, 32'd0);
    chk("R11 rst_req after reset", 32'(rst_req), 32'd0);
    reg_rd(CMD_A, v);  chk("R11 command reg", v, 32'd0);
    reg_rd(STAT_A, v); chk("R11 status reg", v, 32'd0);

    // R1: fill the whole flash
    for (int k = 0; k < FLASH_DEPTH / BUF_DW; k++) begin
      load_buf();
      do_cmd("R1 fill", mkw(4'h0, 4'hF, k * BUF_DW, 1'b0));
    end

    // R2 directed reads
    do_cmd("R2 read cnt0", mkw(4'h2, 4'h0, 37, 1'b0));
    do_cmd("R2 read one", mkw(4'h2, 4'h1, 255, 1'b0));
    do_cmd("R2 read last16", mkw(4'h2, 4'h0, 240, 1'b0));

    // R6 range edges
    do_cmd("R6 read past end", mkw(4'h2, 4'h2, 255, 1'b0));
    load_buf();
    do_cmd("R6 write past end", mkw(4'h0, 4'hF, 250, 1'b0));
    do_cmd("R6 flash intact", mkw(4'h2, 4'h0, 240, 1'b0));
    do_cmd("R6 op3", mkw(4'h3, 4'h0, 0, 1'b0));
    do_cmd("R6 op15", mkw(4'hF, 4'h0, 0, 1'b0));

    // R3 header write ignores address
    load_buf();
    do_cmd("R3 header write", mkw(4'h0, 4'h3, 5, 1'b1));
    do_cmd("R3 header readback", mkw(4'h2, 4'h4, 240, 1'b0));
    do_cmd("R3 addr untouched", mkw(4'h2, 4'h1, 5, 1'b0));

    // R8 authenticate mismatch then match
    bm[0] = ~SIG; reg_wr(5'd0, bm[0]);
    do_cmd("R3 header bad sig", mkw(4'h0, 4'h0, 0, 1'b1));
    do_cmd("R8 auth mismatch", mkw(4'h1, 4'h0, 0, 1'b0));
    bm[0] = SIG; reg_wr(5'd0, bm[0]);
    do_cmd("R3 header good sig", mkw(4'h0, 4'h0, 77, 1'b1));
    do_cmd("R8 auth match", mkw(4'h1, 4'h0, 0, 1'b0));

    // R9 power cycle pulse
    pulses = 0;
    do_cmd("R9 power cycle", mkw(4'h4, 4'h0, 0, 1'b0));
    chk("R9 pulse count", 32'(pulses), 32'd1);

    // R4/R7 writes during busy
    load_buf();
    w1 = mkw(4'h0, 4'h1, 100, 1'b0);
    v = model(w1);
    reg_wr(CMD_A, w1);
    reg_rd(CMD_A, v);
    chk("R4 busy bit set", v, w1);
    reg_wr(CMD_A, mkw(4'h2, 4'h0, 0, 1'b0));
    reg_wr(5'd0, 32'hDEAD_BEEF);
    reg_rd(CMD_A, v);
    chk("R7 cmd unchanged while busy", v, w1);
    wait_done(lat);
    reg_rd(CMD_A, v);
    chk("R4 cmd after done", v, w1 & ~32'd1);
    reg_rd(STAT_A, v);
    chk("R7 status of first cmd", v, 32'h2000_0000);
    last_stat = v;
    check_buf("R7 buffer unchanged");
    do_cmd("R7 flash readback", mkw(4'h2, 4'h2, 100, 1'b0));

    // R7 command without request bit
    pulses = 0;
    reg_wr(CMD_A, mkw(4'h4, 4'h0, 0, 1'b0) & ~32'd1);
    repeat (BUSY_LAT + 6) @(negedge clk);
    reg_rd(STAT_A, v);
    chk("R7 no-request status", v, last_stat);
    chk("R7 no-request pulse", 32'(pulses), 32'd0);

    // random mix
    for (int it = 0; it < 120; it++) begin
      logic [3:0] op;
      int r = int'($urandom % 10);
      op = (r < 4) ? 4'h0 : (r < 8) ? 4'h2 : (r == 8) ? 4'h1 : 4'h3;
      if (op == 4'h0) load_buf();
      do_cmd("R1 R2 random", mkw(op, 4'($urandom), $urandom % 270, ($urandom % 5) == 0));
    end

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule